// File: doc/BRIEF.md
# Stretchable External Data Cycle Generator

This block turns a CPU's external-data load or store request into a timed bus cycle on a simple parallel memory port. It drives an address-valid strobe for the whole access, with a read strobe or a write strobe inside that window. The address and write data are held steady for the whole window. On reads it captures the returned data. When the window closes it gives the CPU a single-cycle completion pulse. While the window is open it keeps the CPU stalled.

A small stretch setting lengthens every access by a number of extra CPU clocks, so that slow memories, or memories shared with other masters, can be reached. The setting is 3 bits wide and so ranges from 0 to 7. Software writes it through a one-cycle configuration write, and it comes out of reset at 1. The value is captured when a request is accepted, so a change takes effect only from the following access.

Top module: `xmem_cycle_gen`

## Requirements
- R1: The stretch setting S (3 bits, 0 to 7) is 1 after reset; a cycle with `cfg_we` high loads `cfg_stretch` into it.
- R2: A request (`req_valid` high) is accepted only when no access is in progress and no completion pulse is showing; a request presented during an access is ignored and does not change the bus address.
- R3: For a read (`req_write` low), `addr_stb` and `rd_stb` are both high for exactly S+1 consecutive cycles, starting in the cycle after acceptance.
- R4: For a write (`req_write` high), `addr_stb` is high for exactly S+2 consecutive cycles, starting in the cycle after acceptance, and `rd_stb` stays low.
- R5: For a write, `wr_stb` first rises in the second cycle of the address window and stays high for S cycles, or for 1 cycle when S is 0.
- R6: `mem_addr` and `mem_wdata` carry the accepted request's values throughout the address window. `rd_stb` and `wr_stb` are never high together, and neither is high outside the address window.
- R7: Read data is the value on `mem_rdata` during the last cycle of `rd_stb`. It appears on `rdata` from the completion cycle onward and is held until the next read completes; writes leave it unchanged.
- R8: `done` is high for exactly one cycle: the cycle right after the last cycle of the address window.
- R9: `stall` is high exactly in the cycles where `addr_stb` is high.
- R10: A stretch write made during an access does not change that access's widths; the next accepted access uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the stretch setting this cycle |
| cfg_stretch | input | 3 | New stretch setting |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| stall | output | 1 | CPU must wait |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | 8 | Captured read data |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| addr_stb | output | 1 | Address-valid strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |

## Verification
Several properties are checked by assertions on every cycle. The read and write strobes are mutually exclusive and only occur inside the address window. The write strobe is never on in the window's first cycle. The address is stable while the window is open, and the completion pulse follows the window's falling edge and lasts one clock. The captured stretch value stays fixed inside a window, and the setting is 1 when reset releases. Only the bench scenarios can show the exact strobe widths for each stretch value, including the one-clock minimum write strobe at stretch 0. They also cover which clock samples the read data, whether a request made while busy is dropped, and whether a mid-access stretch write waits until the next access.

// File: rtl/xmem_pkg.sv
// Package: shared types for the external data cycle generator.
// Assumes: the stretch setting is an unsigned field of at most a few bits.
package xmem_pkg;

    // Access sequencer states: waiting, address window open, completion cycle.
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_ACT  = 2'd1,
        XS_DONE = 2'd2
    } xs_state_t;

endpackage

// File: rtl/xmem_stretch_reg.sv
// Module: xmem_stretch_reg
// Holds the software stretch setting; loads it on a configuration write.
// Assumes: RST_VAL fits in SW bits.
module xmem_stretch_reg #(
    parameter int SW      = 3,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_stretch,
    output logic [SW-1:0] stretch
);

    localparam logic [SW-1:0] RstS = SW'(RST_VAL);

    // Store the setting; reset to the power-on value.
    always_ff @(posedge clk) begin
        if (!rst_n)      stretch <= RstS;
        else if (cfg_we) stretch <= cfg_stretch;
    end

    // R1: the setting holds its power-on value when reset releases
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) |-> stretch == RstS));

endmodule

// File: rtl/xmem_seq.sv
// Module: xmem_seq
// Accepts requests, captures direction and stretch, and counts through the
// address window, then gives a one-cycle completion state.
// Assumes: read window lasts S+1 cycles, write window S+2 cycles.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int SW = 3,
    localparam int CW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [SW-1:0] stretch,
    output logic          accept,
    output logic          in_win,
    output logic          win_last,
    output logic          done,
    output logic          cur_write,
    output logic [SW-1:0] cur_s,
    output logic [CW-1:0] cnt
);

    xs_state_t     state;
    logic [CW-1:0] last_idx;

    // Last window index: S for reads, S+1 for writes.
    always_comb begin
        last_idx = {1'b0, cur_s} + (cur_write ? CW'(1) : CW'(0));
    end

    assign accept   = (state == XS_IDLE) && req_valid;
    assign in_win   = (state == XS_ACT);
    assign win_last = in_win && (cnt == last_idx);
    assign done     = (state == XS_DONE);

    // Sequence one access: accept, count the window, signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= XS_IDLE;
            cnt       <= '0;
            cur_write <= 1'b0;
            cur_s     <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    if (req_valid) begin
                        state     <= XS_ACT;
                        cnt       <= '0;
                        cur_write <= req_write;
                        cur_s     <= stretch;
                    end
                end
                XS_ACT: begin
                    if (cnt == last_idx) state <= XS_DONE;
                    else                 cnt   <= cnt + CW'(1);
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    // R8: completion lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done |=> !done));

    // R10: captured stretch and direction stay fixed inside a window
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_win && !win_last) |=> (in_win && $stable(cur_s) && $stable(cur_write))));

endmodule

// File: rtl/xmem_strobe.sv
// Module: xmem_strobe
// Decodes the bus strobes from the window position and captured settings.
// Assumes: window index 0 is the first address-valid cycle.
module xmem_strobe #(
    parameter int SW = 3,
    localparam int CW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_win,
    input  logic          cur_write,
    input  logic [SW-1:0] cur_s,
    input  logic [CW-1:0] cnt,
    output logic          addr_stb,
    output logic          rd_stb,
    output logic          wr_stb
);

    logic [CW-1:0] wr_end;

    // Write strobe ends at index max(S,1).
    always_comb begin
        wr_end = (cur_s == '0) ? CW'(1) : {1'b0, cur_s};
    end

    assign addr_stb = in_win;
    assign rd_stb   = in_win && !cur_write;
    assign wr_stb   = in_win && cur_write && (cnt >= CW'(1)) && (cnt <= wr_end);

    // R6: strobes exclusive and inside the window
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));
    a_r6_wr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb |-> addr_stb));

    // R5: write strobe never on in the window's first cycle
    a_r5_wr_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_stb) |-> !wr_stb));

endmodule

// File: rtl/xmem_data.sv
// Module: xmem_data
// Latches address and write data on acceptance; captures read data on the
// last read-strobe cycle and holds it.
// Assumes: win_last marks the final address-valid cycle.
module xmem_data #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          rd_last,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] rdata
);

    // Hold request address and data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (accept) begin
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
        end
    end

    // Capture read data at the end of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_last) rdata <= mem_rdata;
    end

endmodule

// File: rtl/xmem_cycle_gen.sv
// Module: xmem_cycle_gen (top)
// Stretchable external data cycle generator: times read/write bus cycles by
// a software stretch setting and stalls the CPU until the access completes.
// Assumes: the CPU holds a request until it is accepted and samples rdata on done.
module xmem_cycle_gen #(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int SW      = 3,
    parameter int RST_STR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_stretch,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          stall,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          addr_stb,
    output logic          rd_stb,
    output logic          wr_stb
);

    localparam int CW = SW + 1;

    logic          accept, in_win, win_last, cur_write;
    logic [SW-1:0] stretch, cur_s;
    logic [CW-1:0] cnt;

    xmem_stretch_reg #(.SW(SW), .RST_VAL(RST_STR)) u_sreg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_stretch(cfg_stretch), .stretch(stretch)
    );

    xmem_seq #(.SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .stretch(stretch), .accept(accept), .in_win(in_win), .win_last(win_last),
        .done(done), .cur_write(cur_write), .cur_s(cur_s), .cnt(cnt)
    );

    xmem_strobe #(.SW(SW)) u_stb (
        .clk(clk), .rst_n(rst_n), .in_win(in_win), .cur_write(cur_write),
        .cur_s(cur_s), .cnt(cnt), .addr_stb(addr_stb), .rd_stb(rd_stb),
        .wr_stb(wr_stb)
    );

    xmem_data #(.AW(AW), .DW(DW)) u_data (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .rd_last(win_last && !cur_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rdata(rdata)
    );

    assign stall = in_win;

    // R8: completion follows the closing of the address window
    a_r8_done_after_win: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(addr_stb) |-> done));

    // R6: address stable while the window stays open
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb |=> (!addr_stb || $stable(mem_addr))));

endmodule

// File: tb/xmem_cycle_gen_tb_top.sv
module xmem_cycle_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_stretch = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  mem_rdata = '0;
    logic        stall, done, addr_stb, rd_stb, wr_stb;
    logic [7:0]  rdata, mem_wdata;
    logic [15:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] last_read = '0;

    always #5 clk = ~clk;

    xmem_cycle_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .stall(stall), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .addr_stb(addr_stb), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_stretch(input logic [2:0] s);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_stretch = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access; exp_s is the stretch the access must use. Optionally pokes a
    // second request and/or writes a new stretch during the first window cycle.
    task automatic run_access(input bit is_wr, input logic [15:0] a, input logic [7:0] d,
                              input int exp_s, input bit poke, input bit mid_cfg,
                              input logic [2:0] mid_s);
        int ac = 0, rc = 0, wc = 0, wfirst = -1, idx = 0, done_idx = -1;
        bit addr_bad = 0, data_bad = 0, stall_bad = 0, excl_bad = 0;
        logic [7:0] exp_rd = last_read;
        int exp_a = is_wr ? exp_s + 2 : exp_s + 1;
        int exp_r = is_wr ? 0 : exp_s + 1;
        int exp_w = is_wr ? ((exp_s == 0) ? 1 : exp_s) : 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = is_wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (idx < 40) begin
            if (stall !== addr_stb) stall_bad = 1;
            if (rd_stb && wr_stb) excl_bad = 1;
            if ((rd_stb || wr_stb) && !addr_stb) excl_bad = 1;
            if (addr_stb) begin
                ac++;
                if (mem_addr !== a) addr_bad = 1;
                if (mem_wdata !== d) data_bad = 1;
            end
            if (rd_stb) begin
                rc++;
                mem_rdata = (a[7:0] ^ 8'hC3) + 8'(idx);
                exp_rd = mem_rdata;
            end
            if (wr_stb) begin
                wc++;
                if (wfirst < 0) wfirst = idx;
            end
            if (poke && idx == 0) begin
                req_valid = 1'b1; req_write = ~is_wr; req_addr = ~a;
            end
            if (mid_cfg && idx == 0) begin
                cfg_we = 1'b1; cfg_stretch = mid_s;
            end
            if (idx == 1) begin
                req_valid = 1'b0; cfg_we = 1'b0;
            end
            if (done) begin
                done_idx = idx;
                break;
            end
            @(negedge clk);
            idx++;
        end
        if (is_wr) begin
            chk(ac == exp_a, "R4 write address width", ac, exp_a);
            chk(rc == 0, "R4 no read strobe on write", rc, 0);
            chk(wc == exp_w, "R5 write strobe width", wc, exp_w);
            chk(wfirst == 1, "R5 write strobe start", wfirst, 1);
        end else begin
            chk(ac == exp_a, "R3 read address width", ac, exp_a);
            chk(rc == exp_r, "R3 read strobe width", rc, exp_r);
            chk(wc == 0, "R6 no write strobe on read", wc, 0);
            last_read = exp_rd;
        end
        chk(!addr_bad, "R6 address held in window", int'(mem_addr), int'(a));
        chk(!data_bad, "R6 write data held in window", int'(mem_wdata), int'(d));
        chk(!excl_bad, "R6 strobe exclusivity", int'(excl_bad), 0);
        chk(!stall_bad, "R9 stall equals address window", int'(stall_bad), 0);
        chk(done_idx == exp_a, "R8 done cycle after window", done_idx, exp_a);
        chk(rdata === last_read, "R7 read data", int'(rdata), int'(last_read));
        req_valid = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        chk(!done, "R8 done one cycle", int'(done), 0);
        chk(!stall && !addr_stb, poke ? "R2 busy request ignored" : "R8 idle after done",
            int'(addr_stb), 0);
        chk(rdata === last_read, "R7 read data held", int'(rdata), int'(last_read));
    endtask

    task automatic t_reset;
        chk(!stall && !done && !addr_stb && !rd_stb && !wr_stb, "R9 reset outputs idle",
            int'({stall, done, addr_stb, rd_stb, wr_stb}), 0);
        chk(rdata == 8'h00, "R7 reset read data", int'(rdata), 0);
    endtask

    task automatic t_default_stretch;
        run_access(1'b0, 16'h1234, 8'h00, 1, 0, 0, 3'd0);   // R1 default S=1
        run_access(1'b1, 16'h2345, 8'h5A, 1, 0, 0, 3'd0);
    endtask

    task automatic t_zero_stretch;
        set_stretch(3'd0);
        run_access(1'b0, 16'h0F0F, 8'h00, 0, 0, 0, 3'd0);   // R3 S=0
        run_access(1'b1, 16'h0F10, 8'hA5, 0, 0, 0, 3'd0);   // R5 minimum width
    endtask

    task automatic t_max_stretch;
        set_stretch(3'd7);
        run_access(1'b0, 16'hFFFE, 8'h00, 7, 0, 0, 3'd0);
        run_access(1'b1, 16'hFFFF, 8'h3C, 7, 0, 0, 3'd0);
    endtask

    task automatic t_mid_change;
        set_stretch(3'd3);
        run_access(1'b1, 16'h4242, 8'h77, 3, 1, 1, 3'd5);   // R2 poke, R10 old S
        run_access(1'b0, 16'h4243, 8'h00, 5, 0, 0, 3'd0);   // R10 new S applies
    endtask

    task automatic t_read_hold;
        set_stretch(3'd2);
        run_access(1'b0, 16'h8001, 8'h00, 2, 0, 0, 3'd0);
        run_access(1'b1, 16'h8002, 8'hE1, 2, 0, 0, 3'd0);   // R7 write keeps rdata
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_stretch();
        t_zero_stretch();
        t_max_stretch();
        t_mid_change();
        t_read_hold();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule